// File: doc/BRIEF.md
# Streaming NAND Page Hamming Parity Generator

This block sits in the data path of a NAND flash controller and builds a single-error-correcting parity code over page data while the bytes stream past. Every 256-byte half of a page yields a pair of 11-bit words. Each data bit has an 11-bit position: the byte's index within the half in the upper eight bits and the bit's position within the byte in the lower three. For every position bit, one word collects the parity of the data bits where that position bit is 1, and the other word collects the parity of the data bits where it is 0.

A host clears the generator before each page and selects either a 256-byte or a 512-byte page. It then presents one byte per strobe, at up to one byte per clock. In 512-byte mode, bytes 256 to 511 feed a second word pair. A done flag reports that the whole page has been absorbed. Software later compares the words read at write time with the words read at read time, and that comparison locates a single flipped bit.

Top module: `nand_ecc_gen`

## Requirements
- R1: While `rst_n` is low, all four parity words are zero and `done` is low.
- R2: Bit k of a "set" word (`ecc_lo_p`, `ecc_hi_p`) is the XOR of every absorbed data bit whose 11-bit position {byte index within its half [7:0], bit number [2:0]} has bit k equal to 1. The byte index counts accepted bytes since the last clear.
- R3: Bit k of a "clear" word (`ecc_lo_n`, `ecc_hi_n`) is the XOR of every absorbed data bit whose position has bit k equal to 0. As a result, all bits of set-word XOR clear-word of the same half are equal.
- R4: With `page_512` high, accepted bytes 256 to 511 go into the high pair, indexed from 0 within that half, and leave the low pair unchanged.
- R5: With `page_512` low, `done` rises after the 256th accepted byte and the high pair never changes.
- R6: With `page_512` high, `done` stays low after the 256th accepted byte and rises after the 512th.
- R7: A cycle with `byte_vld` low, or any byte offered while `done` is high, changes neither the words nor `done`.
- R8: `ecc_clr` zeroes all four words, restarts the byte count and lowers `done`. A byte strobed in the same cycle as the clear is discarded.
- R9: Bytes strobed on consecutive cycles are each absorbed, and a byte's effect is visible on the outputs in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clr | input | 1 | Synchronous clear of the parity words and byte count |
| page_512 | input | 1 | 1 selects a 512-byte page, 0 selects a 256-byte page |
| byte_vld | input | 1 | Byte strobe |
| byte_data | input | 8 | Data byte |
| ecc_lo_p | output | 11 | Set-parity word, bytes 0 to 255 |
| ecc_lo_n | output | 11 | Clear-parity word, bytes 0 to 255 |
| ecc_hi_p | output | 11 | Set-parity word, bytes 256 to 511 |
| ecc_hi_n | output | 11 | Clear-parity word, bytes 256 to 511 |
| done | output | 1 | Page fully absorbed |

## Verification
The clear and the byte strobe can land in the same cycle. The bench drives `ecc_clr` and `byte_vld` together with an all-ones byte. It then expects all words to be zero and the next byte to be treated as byte 0. A single 0x80 byte must therefore give 0x007 and 0x7F8. A byte offered in the cycle that `done` is high is also checked against unchanged outputs. Pages are compared against a bit-by-bit reference computed in the bench.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_BLK_BYTES = 256;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/nand_ecc_contrib.sv
// Per-byte contribution: which parity bits one byte toggles at a given index.
module nand_ecc_contrib #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8,
    localparam int BIT_AW = $clog2(BYTE_W),
    localparam int WORD_W = IDX_W + BIT_AW
) (
    input  logic [BYTE_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] contrib_p,
    output logic [WORD_W-1:0] contrib_n
);
    logic              par;
    logic [BIT_AW-1:0] in_p;
    logic [BIT_AW-1:0] in_n;
    logic [IDX_W-1:0]  ix_p;
    logic [IDX_W-1:0]  ix_n;

    assign par = ^data;

    // in-byte position bits: split the byte by each bit-number bit
    always_comb begin
        in_p = '0;
        in_n = '0;
        for (int k = 0; k < BIT_AW; k++) begin
            for (int j = 0; j < BYTE_W; j++) begin
                if (j[k]) in_p[k] = in_p[k] ^ data[j];
                else      in_n[k] = in_n[k] ^ data[j];
            end
        end
    end

    // byte-index bits: whole-byte parity lands on one side of each pair
    for (genvar gk = 0; gk < IDX_W; gk++) begin : g_idx
        assign ix_p[gk] =  idx[gk] & par;
        assign ix_n[gk] = ~idx[gk] & par;
    end

    assign contrib_p = {ix_p, in_p};
    assign contrib_n = {ix_n, in_n};
endmodule

// File: rtl/nand_ecc_seq.sv
// Byte counter, half select and done flag.
module nand_ecc_seq #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             page_512,
    input  logic             byte_vld,
    output logic             fire,
    output logic             upper,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    typedef struct packed {
        logic [IDX_W:0] cnt;
        logic           done;
    } seq_t;

    seq_t st_d, st_q;
    logic is_last;

    assign fire    = byte_vld & ~st_q.done & ~clr;
    assign is_last = (st_q.cnt[IDX_W-1:0] == '1) && (!page_512 || st_q.cnt[IDX_W]);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (fire) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (is_last) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upper = page_512 & st_q.cnt[IDX_W];
    assign idx   = st_q.cnt[IDX_W-1:0];
    assign done  = st_q.done;
endmodule

// File: rtl/nand_ecc_bank.sv
// One parity word pair for one half-page.
module nand_ecc_bank #(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [WORD_W-1:0] contrib_p,
    input  logic [WORD_W-1:0] contrib_n,
    output logic [WORD_W-1:0] acc_p,
    output logic [WORD_W-1:0] acc_n
);
    typedef struct packed {
        logic [WORD_W-1:0] p;
        logic [WORD_W-1:0] n;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.p = st_q.p ^ contrib_p;
            st_d.n = st_q.n ^ contrib_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_p = st_q.p;
    assign acc_n = st_q.n;
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int BYTE_W    = DEF_BYTE_W,
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    localparam int IDX_W    = $clog2(BLK_BYTES),
    localparam int BIT_AW   = $clog2(BYTE_W),
    localparam int WORD_W   = IDX_W + BIT_AW,
    localparam int NUM_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_clr,
    input  logic              page_512,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [WORD_W-1:0] ecc_lo_p,
    output logic [WORD_W-1:0] ecc_lo_n,
    output logic [WORD_W-1:0] ecc_hi_p,
    output logic [WORD_W-1:0] ecc_hi_n,
    output logic              done
);
    logic              fire;
    logic              upper;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] contrib_p;
    logic [WORD_W-1:0] contrib_n;
    logic [WORD_W-1:0] acc_p [NUM_HALF];
    logic [WORD_W-1:0] acc_n [NUM_HALF];
    half_e             half_sel;

    nand_ecc_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ecc_clr),
        .page_512 (page_512),
        .byte_vld (byte_vld),
        .fire     (fire),
        .upper    (upper),
        .idx      (idx),
        .done     (done)
    );

    nand_ecc_contrib #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_contrib (
        .data      (byte_data),
        .idx       (idx),
        .contrib_p (contrib_p),
        .contrib_n (contrib_n)
    );

    assign half_sel = upper ? HALF_HI : HALF_LO;

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_bank
        logic en_h;
        assign en_h = fire && (half_sel == half_e'(h));
        nand_ecc_bank #(.WORD_W(WORD_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (ecc_clr),
            .en        (en_h),
            .contrib_p (contrib_p),
            .contrib_n (contrib_n),
            .acc_p     (acc_p[h]),
            .acc_n     (acc_n[h])
        );
    end

    assign ecc_lo_p = acc_p[HALF_LO];
    assign ecc_lo_n = acc_n[HALF_LO];
    assign ecc_hi_p = acc_p[HALF_HI];
    assign ecc_hi_n = acc_n[HALF_HI];
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
    parameter int WORD_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecc_clr,
    input logic              page_512,
    input logic              byte_vld,
    input logic [WORD_W-1:0] ecc_lo_p,
    input logic [WORD_W-1:0] ecc_lo_n,
    input logic [WORD_W-1:0] ecc_hi_p,
    input logic [WORD_W-1:0] ecc_hi_n,
    input logic              done
);
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (ecc_lo_p == '0 && ecc_lo_n == '0 && ecc_hi_p == '0 && ecc_hi_n == '0 && !done));

    p_pair_balance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((ecc_lo_p ^ ecc_lo_n) == '0) || ((ecc_lo_p ^ ecc_lo_n) == '1)) &&
        (((ecc_hi_p ^ ecc_hi_n) == '0) || ((ecc_hi_p ^ ecc_hi_n) == '1)));

    p_hi_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_512 && !ecc_clr) |=> ($stable(ecc_hi_p) && $stable(ecc_hi_n)));

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(byte_vld));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !ecc_clr) |=> ($stable(ecc_lo_p) && $stable(ecc_lo_n) &&
                                      $stable(ecc_hi_p) && $stable(ecc_hi_n) && $stable(done)));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ecc_clr) |=> (done && $stable(ecc_lo_p) && $stable(ecc_lo_n) &&
                                $stable(ecc_hi_p) && $stable(ecc_hi_n)));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (ecc_lo_p == '0 && ecc_lo_n == '0 && ecc_hi_p == '0 && ecc_hi_n == '0 && !done));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ecc_clr  (ecc_clr),
    .page_512 (page_512),
    .byte_vld (byte_vld),
    .ecc_lo_p (ecc_lo_p),
    .ecc_lo_n (ecc_lo_n),
    .ecc_hi_p (ecc_hi_p),
    .ecc_hi_n (ecc_hi_n),
    .done     (done)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_clr = 1'b0;
    logic        page_512 = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [10:0] ecc_lo_p, ecc_lo_n, ecc_hi_p, ecc_hi_n;
    logic        done;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] page_mem [0:511];

    typedef struct packed {
        logic        p512;
        logic [1:0]  kind;   // 0 hashed, 1 single bit, 2 all ones, 3 zeros
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 2'd0, 32'h1234_5678},
        '{1'b1, 2'd0, 32'h9E37_79B9},
        '{1'b0, 2'd1, 32'h0000_0A6A},   // byte 106 bit 5
        '{1'b1, 2'd1, 32'h0000_0F2C},   // byte 300 bit 7
        '{1'b1, 2'd2, 32'h0000_0000},
        '{1'b0, 2'd3, 32'h0000_0000},
        '{1'b1, 2'd0, 32'hC0FF_EE01}
    };

    nand_ecc_gen uut (
        .clk(clk), .rst_n(rst_n), .ecc_clr(ecc_clr), .page_512(page_512),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .ecc_lo_p(ecc_lo_p), .ecc_lo_n(ecc_lo_n),
        .ecc_hi_p(ecc_hi_p), .ecc_hi_n(ecc_hi_n), .done(done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog (all requirements): actual %0d cycles, expected under 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(logic [1:0] kind, logic [31:0] seed, int idx);
        logic [31:0] x;
        case (kind)
            2'd0: begin
                x = seed ^ (32'(idx) * 32'h9E37_79B1);
                x = x ^ (x >> 15);
                x = x * 32'h85EB_CA6B;
                x = x ^ (x >> 13);
                return x[7:0] ^ x[23:16];
            end
            2'd1: return (idx == int'(seed[8:0])) ? 8'(1 << seed[11:9]) : 8'h00;
            2'd2: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // bit-by-bit reference over one 256-byte half
    task automatic ref_half(input int base, output logic [10:0] p, output logic [10:0] n);
        p = '0;
        n = '0;
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [10:0] a;
                a = {i[7:0], j[2:0]};
                for (int k = 0; k < 11; k++) begin
                    if (a[k]) p[k] = p[k] ^ page_mem[base + i][j];
                    else      n[k] = n[k] ^ page_mem[base + i][j];
                end
            end
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        ecc_clr = 1'b1;
        @(negedge clk);
        ecc_clr = 1'b0;
    endtask

    // one byte followed by an idle cycle carrying junk data
    task automatic send_gap(input logic [7:0] d);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = d;
        @(negedge clk);
        byte_vld  = 1'b0;
        byte_data = ~d;
    endtask

    task automatic run_page(input vec_t v, input bit burst);
        int nbytes;
        logic [10:0] lp, ln, hp, hn;
        nbytes = v.p512 ? 512 : 256;
        for (int i = 0; i < 512; i++) page_mem[i] = (i < nbytes) ? gen_byte(v.kind, v.seed, i) : 8'h00;
        page_512 = v.p512;
        pulse_clear();
        ref_half(0, lp, ln);
        if (v.p512) ref_half(256, hp, hn);
        else begin hp = '0; hn = '0; end
        if (burst) begin
            for (int i = 0; i < nbytes; i++) begin
                @(negedge clk);
                byte_vld  = 1'b1;
                byte_data = page_mem[i];
            end
            @(negedge clk);
            byte_vld = 1'b0;
        end else begin
            for (int i = 0; i < nbytes; i++) begin
                send_gap(page_mem[i]);
                if (v.p512 && i == 255) begin
                    chk(done == 1'b0, "R6 done low after byte 256", 32'(done), 32'd0);
                    chk(ecc_lo_p == lp, "R2 low set word at half boundary", 32'(ecc_lo_p), 32'(lp));
                end
            end
        end
        chk(done == 1'b1, v.p512 ? "R6 done after byte 512" : "R5 done after byte 256", 32'(done), 32'd1);
        chk(ecc_lo_p == lp, burst ? "R9 R2 low set word" : "R2 R7 low set word", 32'(ecc_lo_p), 32'(lp));
        chk(ecc_lo_n == ln, burst ? "R9 R3 low clear word" : "R3 R7 low clear word", 32'(ecc_lo_n), 32'(ln));
        chk(ecc_hi_p == hp, v.p512 ? "R4 high set word" : "R5 high set word stays zero", 32'(ecc_hi_p), 32'(hp));
        chk(ecc_hi_n == hn, v.p512 ? "R4 high clear word" : "R5 high clear word stays zero", 32'(ecc_hi_n), 32'(hn));
    endtask

    initial begin
        logic [10:0] sp, sn, shp, shn;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ecc_lo_p == 0 && ecc_lo_n == 0 && ecc_hi_p == 0 && ecc_hi_n == 0,
            "R1 words zero in reset", 32'({ecc_lo_p, ecc_lo_n}), 32'd0);
        chk(done == 1'b0, "R1 done low in reset", 32'(done), 32'd0);
        rst_n = 1'b1;

        // vector table: every page once with idle gaps, once back to back
        for (int v = 0; v < 7; v++) begin
            run_page(VECS[v], 1'b0);
            run_page(VECS[v], 1'b1);
        end

        // R7: bytes after done are ignored
        sp = ecc_lo_p; sn = ecc_lo_n; shp = ecc_hi_p; shn = ecc_hi_n;
        for (int i = 0; i < 3; i++) send_gap(8'hFF);
        chk(ecc_lo_p == sp && ecc_lo_n == sn, "R7 low pair frozen after done", 32'(ecc_lo_p), 32'(sp));
        chk(ecc_hi_p == shp && ecc_hi_n == shn, "R7 high pair frozen after done", 32'(ecc_hi_p), 32'(shp));
        chk(done == 1'b1, "R7 done stays high", 32'(done), 32'd1);

        // R8: clear and byte strobe in the same cycle
        page_512 = 1'b0;
        @(negedge clk);
        ecc_clr   = 1'b1;
        byte_vld  = 1'b1;
        byte_data = 8'hFF;
        @(negedge clk);
        ecc_clr  = 1'b0;
        byte_vld = 1'b0;
        chk(ecc_lo_p == 0 && ecc_lo_n == 0 && ecc_hi_p == 0 && ecc_hi_n == 0,
            "R8 words zero after clear with byte", 32'({ecc_lo_p, ecc_lo_n}), 32'd0);
        chk(done == 1'b0, "R8 done low after clear", 32'(done), 32'd0);
        // next byte must be byte 0: 0x80 sits at position 7
        send_gap(8'h80);
        chk(ecc_lo_p == 11'h007, "R8 R2 first byte after clear set word", 32'(ecc_lo_p), 32'h007);
        chk(ecc_lo_n == 11'h7F8, "R8 R3 first byte after clear clear word", 32'(ecc_lo_n), 32'h7F8);
        chk(done == 1'b0, "R5 done low mid page", 32'(done), 32'd0);

        // R8: clear in the middle of a page restarts the count
        for (int i = 0; i < 9; i++) send_gap(8'(i * 37 + 5));
        run_page(VECS[1], 1'b1);

        // R1: reset mid page
        page_512 = 1'b1;
        for (int i = 0; i < 5; i++) send_gap(8'hA5);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ecc_lo_p == 0 && ecc_lo_n == 0 && ecc_hi_p == 0 && ecc_hi_n == 0 && done == 1'b0,
            "R1 reset mid page", 32'({ecc_lo_p, ecc_lo_n}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule